// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating converter. It drives the three analog switches around the integrator and measures the conversion result as a time interval. After a start request it first shorts the integrator for a set number of cycles to clear it. It then connects the unknown voltage for a fixed number of clock cycles. Finally it connects the known reference of opposite polarity and counts cycles until the zero-crossing comparator trips.

That count is the conversion result. The fixed run-up and the variable run-down are both timed by one shared counter on one clock. Any error in the integrator's resistor, capacitor or clock rate therefore divides out of the ratio. If the comparator never trips within the full count range, the result saturates at full scale and an overrange flag is raised.

A one-cycle done strobe marks completion. The result and the flag stay on the outputs until the next accepted start.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all switch selects, `done_o`, `over_o` and `result_o` are 0 after that edge.
- R2: A start sampled high while idle makes `sel_zero_o` the only active select from the next cycle, for exactly AZ_CYCLES cycles.
- R3: The integrator reset phase is followed by exactly INT_CYCLES cycles with only `sel_in_o` active. The de-integration phase then follows, with only `sel_ref_o` active.
- R4: At most one switch select is active in any cycle. In idle, all selects are released and `done_o` is low.
- R5: In de-integration, the comparator is sampled once per cycle. If it is first seen high in the de-integration cycle with index k (the first cycle is index 0), the result is k and `done_o` rises in the next cycle.
- R6: If the comparator stays low for 2^N de-integration cycles, the result is 2^N-1 (all ones) and `over_o` is 1. `over_o` is 0 whenever the comparator tripped.
- R7: `done_o` is high for exactly one cycle, after which the block is idle. `result_o` and `over_o` hold their values until the next accepted start, which clears both to 0 in the first reset-phase cycle.
- R8: A start request while a conversion is running, or in the done cycle, is ignored and does not change the phase timing.
- R9: The comparator input has no effect outside the de-integration phase.
- R10: In the done cycle, `sel_zero_o` is asserted together with `done_o` to begin discharging the integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the single time base for both phases |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only while idle |
| cmp_i | input | 1 | Comparator: high once the integrator has crossed zero |
| sel_zero_o | output | 1 | Integrator reset switch select |
| sel_in_o | output | 1 | Unknown-input switch select |
| sel_ref_o | output | 1 | Reference switch select |
| result_o | output | N | De-integration cycle count |
| done_o | output | 1 | One-cycle completion strobe |
| over_o | output | 1 | Overrange: comparator never tripped |

## Verification
The assertions take the comparator and start inputs to be synchronous to `clk` and settled before each rising edge. They make no assumption about when either input is high, because the block must tolerate both at any time. The stimulus changes every input only on the falling edge. It deliberately holds the comparator high during the reset and integration phases, and raises start during integration and in the done cycle. This keeps the stimulus within those assumptions while exercising the cases where the inputs must be ignored.

// File: rtl/dsadc_pkg.sv
// Package: shared phase encoding for the dual-slope sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsadc_pkg;

    // Conversion phases in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ZERO  = 3'd1,
        PH_RUNUP = 3'd2,
        PH_RUNDN = 3'd3,
        PH_DONE  = 3'd4
    } phase_t;

    // Switch select bundle driven toward the analog front end.
    typedef struct packed {
        logic zero;
        logic inp;
        logic ref_sel;
    } sw_sel_t;

endpackage

// File: rtl/dsadc_phase_timer.sv
// Module: dsadc_phase_timer
// Shared cycle counter timing every phase of a conversion.
// One counter times both run-up and run-down, so both phases
// use the same clock as their time base.
// Assumes: clr has priority over inc.
module dsadc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Clear on phase entry, otherwise advance when told to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dsadc_ctrl.sv
// Module: dsadc_ctrl
// Phase state machine: idle -> zero -> run-up -> run-down -> done.
// Produces timer control and result capture strobes.
// Assumes: AZ_CYCLES and INT_CYCLES are at least 1 and fit in TW bits;
// cmp is synchronous to clk.
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int N          = 8,
    parameter int AZ_CYCLES  = 8,
    parameter int INT_CYCLES = 256,
    parameter int TW         = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cmp,
    input  logic [TW-1:0] cnt,
    output phase_t        phase,
    output logic          tmr_clr,
    output logic          tmr_inc,
    output logic          res_clr,
    output logic          cap_trip,
    output logic          cap_over
);

    localparam logic [TW-1:0] AZ_LAST  = TW'(AZ_CYCLES - 1);
    localparam logic [TW-1:0] INT_LAST = TW'(INT_CYCLES - 1);
    localparam logic [TW-1:0] DN_LAST  = TW'((1 << N) - 1);

    phase_t ph_nxt;
    logic   az_end;
    logic   int_end;
    logic   dn_end;

    // Terminal-count flags for each timed phase.
    always_comb begin
        az_end  = (cnt == AZ_LAST);
        int_end = (cnt == INT_LAST);
        dn_end  = (cnt == DN_LAST);
    end

    // Next-phase and strobe decode.
    always_comb begin
        ph_nxt   = phase;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        res_clr  = 1'b0;
        cap_trip = 1'b0;
        cap_over = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    ph_nxt  = PH_ZERO;
                    tmr_clr = 1'b1;
                    res_clr = 1'b1;
                end
            end
            PH_ZERO: begin
                if (az_end) begin
                    ph_nxt  = PH_RUNUP;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            PH_RUNUP: begin
                if (int_end) begin
                    ph_nxt  = PH_RUNDN;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            PH_RUNDN: begin
                if (cmp) begin
                    ph_nxt   = PH_DONE;
                    cap_trip = 1'b1;
                end else if (dn_end) begin
                    ph_nxt   = PH_DONE;
                    cap_over = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            PH_DONE: begin
                ph_nxt = PH_IDLE;
            end
            default: begin
                ph_nxt = PH_IDLE;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= ph_nxt;
        end
    end

endmodule

// File: rtl/dsadc_capture.sv
// Module: dsadc_capture
// Holds the conversion count and overrange flag between conversions.
// Assumes: at most one of clr, trip, over is high in a cycle.
module dsadc_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         trip,
    input  logic         over,
    input  logic [N-1:0] cnt,
    output logic [N-1:0] result,
    output logic         ovr
);

    // Latch the run-down count on trip, saturate on overrange.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            result <= '0;
            ovr    <= 1'b0;
        end else if (trip) begin
            result <= cnt;
            ovr    <= 1'b0;
        end else if (over) begin
            result <= '1;
            ovr    <= 1'b1;
        end
    end

endmodule

// File: rtl/dsadc_sw_dec.sv
// Module: dsadc_sw_dec
// Maps the phase to the switch selects; one select per active phase.
// Assumes: phase comes straight from a register, so outputs are glitch-free
// apart from decode delay.
module dsadc_sw_dec
    import dsadc_pkg::*;
(
    input  phase_t  phase,
    output sw_sel_t sel,
    output logic    done
);

    // Phase-to-switch decode; done also discharges the integrator.
    always_comb begin
        sel  = '0;
        done = 1'b0;
        unique case (phase)
            PH_ZERO:  sel.zero    = 1'b1;
            PH_RUNUP: sel.inp     = 1'b1;
            PH_RUNDN: sel.ref_sel = 1'b1;
            PH_DONE: begin
                sel.zero = 1'b1;
                done     = 1'b1;
            end
            default:  sel = '0;
        endcase
    end

endmodule

// File: rtl/dsadc_seq.sv
// Module: dsadc_seq (top)
// Dual-slope converter sequencer: integrator reset, fixed run-up,
// timed run-down with saturation at 2^N cycles.
// Assumes: start_i and cmp_i are synchronous to clk.
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int N          = 8,
    parameter int AZ_CYCLES  = 8,
    parameter int INT_CYCLES = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         sel_zero_o,
    output logic         sel_in_o,
    output logic         sel_ref_o,
    output logic [N-1:0] result_o,
    output logic         done_o,
    output logic         over_o
);

    localparam int AZ_W  = $clog2(AZ_CYCLES + 1);
    localparam int INT_W = $clog2(INT_CYCLES + 1);
    localparam int TW0   = (AZ_W > INT_W) ? AZ_W : INT_W;
    localparam int TW    = (TW0 > N) ? TW0 : N;

    logic [TW-1:0] cnt;
    phase_t        phase;
    sw_sel_t       sel;
    logic          tmr_clr;
    logic          tmr_inc;
    logic          res_clr;
    logic          cap_trip;
    logic          cap_over;

    dsadc_phase_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .cnt   (cnt)
    );

    dsadc_ctrl #(
        .N          (N),
        .AZ_CYCLES  (AZ_CYCLES),
        .INT_CYCLES (INT_CYCLES),
        .TW         (TW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .cmp      (cmp_i),
        .cnt      (cnt),
        .phase    (phase),
        .tmr_clr  (tmr_clr),
        .tmr_inc  (tmr_inc),
        .res_clr  (res_clr),
        .cap_trip (cap_trip),
        .cap_over (cap_over)
    );

    dsadc_capture #(.N(N)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (res_clr),
        .trip   (cap_trip),
        .over   (cap_over),
        .cnt    (cnt[N-1:0]),
        .result (result_o),
        .ovr    (over_o)
    );

    dsadc_sw_dec u_dec (
        .phase (phase),
        .sel   (sel),
        .done  (done_o)
    );

    // Unpack the select bundle onto the ports.
    always_comb begin
        sel_zero_o = sel.zero;
        sel_in_o   = sel.inp;
        sel_ref_o  = sel.ref_sel;
    end

endmodule

// File: rtl/dsadc_seq_chk.sv
// Module: dsadc_seq_chk
// Port-level protocol checks for dsadc_seq, attached by bind.
// Assumes: inputs are synchronous to clk.
module dsadc_seq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         cmp_i,
    input logic         sel_zero_o,
    input logic         sel_in_o,
    input logic         sel_ref_o,
    input logic [N-1:0] result_o,
    input logic         done_o,
    input logic         over_o
);

    logic idle_w;

    // Idle is visible at the ports as no select active.
    always_comb idle_w = !sel_zero_o && !sel_in_o && !sel_ref_o;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_zero_o, sel_in_o, sel_ref_o})); // R4

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |-> !done_o); // R4

    AST_START_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && start_i) |=> sel_zero_o); // R2

    AST_RUNUP_TO_RUNDN: assert property (@(posedge clk) disable iff (!rst_n)
        sel_in_o |=> (sel_in_o || sel_ref_o)); // R3

    AST_TRIP_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ref_o && cmp_i) |=> (done_o && !over_o)); // R5

    AST_OVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (result_o == {N{1'b1}})); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && idle_w)); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && !start_i) |=> ($stable(result_o) && $stable(over_o))); // R7

    AST_DONE_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sel_zero_o); // R10

    AST_RUNUP_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in_o && cmp_i) |=> !done_o); // R9

endmodule

bind dsadc_seq dsadc_seq_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_i      (cmp_i),
    .sel_zero_o (sel_zero_o),
    .sel_in_o   (sel_in_o),
    .sel_ref_o  (sel_ref_o),
    .result_o   (result_o),
    .done_o     (done_o),
    .over_o     (over_o)
);

// File: tb/tb_dsadc_seq.sv
// Bench for dsadc_seq: a table of run-down trip points walked by one
// loop, then directed reset and corner-case tests.
module tb_dsadc_seq;

    localparam int N    = 6;
    localparam int AZ   = 4;
    localparam int INTC = 64;
    localparam int FULL = (1 << N);
    localparam int NV   = 8;
    // Trip index per vector (>= FULL means never trips) and noise flag.
    localparam int VEC_TRIP  [NV] = '{0, 1, 17, 40, 62, 63, 64, 5};
    localparam int VEC_NOISE [NV] = '{0, 0, 1, 0, 0, 1, 1, 0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b0;
    logic         sel_zero_o, sel_in_o, sel_ref_o;
    logic [N-1:0] result_o;
    logic         done_o, over_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    dsadc_seq #(.N(N), .AZ_CYCLES(AZ), .INT_CYCLES(INTC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .sel_zero_o (sel_zero_o),
        .sel_in_o   (sel_in_o),
        .sel_ref_o  (sel_ref_o),
        .result_o   (result_o),
        .done_o     (done_o),
        .over_o     (over_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sels();
        return {29'd0, sel_zero_o, sel_in_o, sel_ref_o};
    endfunction

    // One conversion from idle; trip >= FULL means the comparator never trips.
    task automatic run_conv(input int trip, input bit noise, input bit start_at_done);
        int  k;
        bit  tripped;
        int  exp_res;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check("R7 result cleared by start", int'(result_o), 0);
        check("R7 over cleared by start", int'(over_o), 0);
        for (int i = 0; i < AZ; i++) begin
            check("R2 zero phase", sels(), 4);
            if (noise) cmp_i = 1'b1;
            @(negedge clk);
        end
        for (int i = 0; i < INTC; i++) begin
            check(noise ? "R3 R8 R9 run-up" : "R3 run-up", sels(), 2);
            check(noise ? "R9 no early done" : "R4 no done", int'(done_o), 0);
            if (noise) begin
                cmp_i   = 1'b1;
                start_i = (i == 3);
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        cmp_i   = 1'b0;
        k = 0;
        tripped = 1'b0;
        while (!tripped && k < FULL) begin
            check("R3 run-down", sels(), 1);
            cmp_i = (k == trip);
            if (k == trip) tripped = 1'b1;
            k++;
            @(negedge clk);
        end
        cmp_i = 1'b0;
        exp_res = (trip >= FULL) ? FULL - 1 : trip;
        check("R7 done high", int'(done_o), 1);
        check("R10 discharge in done", sels(), 4);
        check(trip >= FULL ? "R6 saturated result" : "R5 result", int'(result_o), exp_res);
        check("R6 over flag", int'(over_o), (trip >= FULL) ? 1 : 0);
        if (start_at_done) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R7 done single cycle", int'(done_o), 0);
        check(start_at_done ? "R8 start in done ignored" : "R4 idle released", sels(), 0);
        check("R7 result held", int'(result_o), exp_res);
        @(negedge clk);
        check(start_at_done ? "R8 still idle" : "R4 still idle", sels(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 selects in reset", sels(), 0);
        check("R1 done in reset", int'(done_o), 0);
        check("R1 result in reset", int'(result_o), 0);
        check("R1 over in reset", int'(over_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle after reset", sels(), 0);

        for (int v = 0; v < NV; v++) begin
            run_conv(VEC_TRIP[v], VEC_NOISE[v] != 0, 1'b0);
        end

        // Result holds while idle although cmp toggles (R7, R9).
        for (int i = 0; i < 6; i++) begin
            cmp_i = i[0];
            @(negedge clk);
            check("R9 idle cmp ignored", int'(result_o), 5);
            check("R9 idle no done", int'(done_o), 0);
        end
        cmp_i = 1'b0;

        // Start during the done cycle is ignored (R8).
        run_conv(9, 1'b0, 1'b1);

        // Reset in the middle of run-up (R1).
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 selects after mid reset", sels(), 0);
        check("R1 result after mid reset", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after mid reset", sels(), 0);

        // Trip at the last possible run-down cycle, after reset.
        run_conv(FULL - 1, 1'b0, 1'b0);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule